// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a link to a small 8-bit successive-approximation converter with a three-wire serial output. On a start request it drives the converter's channel/range select pin, pulls the shared chip-select/output-enable line low, and produces a serial clock from a programmable divider of the system clock. It samples the data line on every rising clock edge and releases chip-select after the last edge. It then presents the 8-bit conversion result together with a one-cycle valid strobe.

Two frame lengths are offered, chosen per request. The byte frame gives sixteen clocks, which matches two back-to-back 8-bit transfers. The minimal frame stops after twelve clocks, the fewest that deliver the whole result. In both, the first four sampled bits are padding that must be zero, and any one among them flags an error. Both supported clock modes sample on the rising edge. The idle level of the serial clock selects between them, and the clock phase always equals the polarity. A programmable gap keeps chip-select high for a minimum time before the next request is accepted.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted, chip-select is high, the serial clock is low, busy and done are low, and the result and error outputs are zero.
- R2: Whenever chip-select is high and no request is in progress, the serial clock rests at the level of `cpol_i`, following it one cycle later. The serial clock never changes in the cycle in which chip-select falls or rises, so the clock phase equals the polarity.
- R3: A frame contains exactly 16 rising serial-clock edges when `minimal_i` was 0 at the accepted start, and exactly 12 when it was 1.
- R4: With D = `div_i` latched at the accepted start (0 treated as 1), the following intervals are each exactly D system clocks: from the cycle busy rises to chip-select falling, from chip-select falling to the first clock transition, between successive clock transitions, and from the last transition to chip-select rising.
- R5: `adc_sel_o` takes `sel_i` in the cycle busy rises and holds that value while chip-select is low. It is therefore set up D cycles before chip-select falls and stays stable through the first rising edge.
- R6: The data line is sampled on rising serial-clock edges. The bits taken at rising edges 5 through 12 (counting from 1) form `result_o`, with edge 5 as bit 7 (MSB) and edge 12 as bit 0. Data sampled at edges 13 to 16 of a byte frame has no effect on the outputs.
- R7: `done_o` is a one-cycle pulse in the first cycle that chip-select is high again. `result_o` and `err_o` change only in that cycle.
- R8: `err_o` reported with a result is 1 exactly when at least one of the bits sampled at rising edges 1 to 4 was 1.
- R9: `start_i` is ignored while `busy_o` is high. It does not begin another frame, and it does not change `adc_sel_o` or the latched settings.
- R10: With G = `gap_i` latched at the accepted start, `busy_o` stays high for exactly max(G,1) cycles counting the `done_o` cycle, and then falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion read (taken when not busy) |
| minimal_i | input | 1 | 1 = 12-clock frame, 0 = 16-clock byte frame |
| cpol_i | input | 1 | Serial clock idle level (phase equals polarity) |
| sel_i | input | 1 | Value for the converter's range/channel select pin |
| div_i | input | DIV_W | Serial clock half-period in system clocks (0 acts as 1) |
| gap_i | input | GAP_W | Minimum post-frame hold-off in system clocks |
| adc_miso_i | input | 1 | Serial data from the converter |
| adc_cs_n_o | output | 1 | Combined chip-select / output-enable, active low |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| adc_sel_o | output | 1 | Range/channel select pin |
| busy_o | output | 1 | Request in progress, including the hold-off |
| done_o | output | 1 | One-cycle result valid strobe |
| result_o | output | RESULT_W | Conversion result, MSB first on the wire |
| err_o | output | 1 | A padding bit was 1 in the last frame |

## Verification
A wrong toggle count or state in the sequencer shows up as a wrong number of rising edges before chip-select releases. It can also appear as a clock level at chip-select rise that differs from the idle level, and both are caught at the end of that same frame. A divider fault shows up at the very next clock transition, because every interval from busy rise onward is timed against the latched half-period. A wrong bit position in capture only becomes visible at the done strobe, as a wrong result or error flag. The bench therefore drives distinct bit patterns, non-zero padding and non-zero trailing bits so that such a fault shows at the first frame it affects.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_LEAD  = 3'd2,
      ST_SHIFT = 3'd3,
      ST_GAP   = 3'd4
   } rd_state_e;

endpackage

// File: rtl/adc_rd_tick.sv
// Half-period timer: pulses tick_o every div_i cycles while not cleared.
module adc_rd_tick #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   assign tick_o = !clr_i && (cnt_q == div_i - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/adc_rd_seq.sv
// Frame sequencer: setup, chip-select, clock toggles, hold-off.
module adc_rd_seq
   import adc_rd_pkg::*;
#(
   parameter int DIV_W     = 12,
   parameter int GAP_W     = 8,
   parameter int MIN_CLKS  = 12,
   parameter int FULL_CLKS = 16,
   parameter int IDX_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             minimal_i,
   input  logic             cpol_i,
   input  logic             sel_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [GAP_W-1:0] gap_i,
   input  logic             tick_i,
   output logic             tick_clr_o,
   output logic [DIV_W-1:0] div_o,
   output logic             cs_n_o,
   output logic             sclk_o,
   output logic             sel_o,
   output logic             busy_o,
   output logic             frame_start_o,
   output logic             sample_o,
   output logic [IDX_W-1:0] sample_idx_o,
   output logic             frame_end_o
);

   localparam int TOG_W = $clog2(2 * FULL_CLKS + 1);
   localparam logic [TOG_W-1:0] MIN_TOG  = TOG_W'(2 * MIN_CLKS);
   localparam logic [TOG_W-1:0] FULL_TOG = TOG_W'(2 * FULL_CLKS);

   rd_state_e        state_q;
   logic [TOG_W-1:0] tog_q;
   logic             mode_q;
   logic [DIV_W-1:0] div_q;
   logic [GAP_W-1:0] gap_q;
   logic [GAP_W-1:0] gcnt_q;
   logic             cs_n_q;
   logic             sclk_q;
   logic             sel_q;

   logic [TOG_W-1:0] last_tog;
   logic             edge_due;
   logic             accept;
   logic [GAP_W:0]   gnext;

   assign last_tog = mode_q ? MIN_TOG : FULL_TOG;
   assign accept   = (state_q == ST_IDLE) && start_i;
   assign edge_due = tick_i && ((state_q == ST_LEAD) ||
                     ((state_q == ST_SHIFT) && (tog_q != last_tog)));
   assign gnext    = {1'b0, gcnt_q} + 1'b1;

   assign frame_end_o   = tick_i && (state_q == ST_SHIFT) && (tog_q == last_tog);
   assign sample_o      = edge_due && !sclk_q;
   assign sample_idx_o  = tog_q[IDX_W:1];
   assign frame_start_o = accept;
   assign tick_clr_o    = (state_q == ST_IDLE) || (state_q == ST_GAP);
   assign busy_o        = (state_q != ST_IDLE);
   assign div_o         = div_q;
   assign cs_n_o        = cs_n_q;
   assign sclk_o        = sclk_q;
   assign sel_o         = sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tog_q   <= '0;
         mode_q  <= 1'b0;
         div_q   <= DIV_W'(1);
         gap_q   <= '0;
         gcnt_q  <= '0;
         cs_n_q  <= 1'b1;
         sclk_q  <= 1'b0;
         sel_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               sclk_q <= cpol_i;
               if (start_i) begin
                  state_q <= ST_SETUP;
                  mode_q  <= minimal_i;
                  sel_q   <= sel_i;
                  div_q   <= (div_i == '0) ? DIV_W'(1) : div_i;
                  gap_q   <= gap_i;
                  tog_q   <= '0;
               end
            end
            ST_SETUP: begin
               if (tick_i) begin
                  state_q <= ST_LEAD;
                  cs_n_q  <= 1'b0;
               end
            end
            ST_LEAD: begin
               if (edge_due) begin
                  sclk_q  <= ~sclk_q;
                  tog_q   <= tog_q + 1'b1;
                  state_q <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (frame_end_o) begin
                  cs_n_q  <= 1'b1;
                  gcnt_q  <= '0;
                  state_q <= ST_GAP;
               end else if (edge_due) begin
                  sclk_q <= ~sclk_q;
                  tog_q  <= tog_q + 1'b1;
               end
            end
            ST_GAP: begin
               if (gnext >= {1'b0, gap_q}) begin
                  state_q <= ST_IDLE;
               end else begin
                  gcnt_q <= gcnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adc_rd_capture.sv
// Bit capture: padding check and result assembly, published at frame end.
module adc_rd_capture #(
   parameter int LEAD_W   = 4,
   parameter int RESULT_W = 8,
   parameter int IDX_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  logic                sample_i,
   input  logic [IDX_W-1:0]    idx_i,
   input  logic                miso_i,
   input  logic                end_i,
   output logic [RESULT_W-1:0] result_o,
   output logic                err_o,
   output logic                valid_o
);

   localparam logic [IDX_W-1:0] LEAD_IDX = IDX_W'(LEAD_W);

   logic [RESULT_W-1:0] data_q;
   logic                pad_err_q;

   for (genvar i = 0; i < RESULT_W; i++) begin : g_bit
      localparam logic [IDX_W-1:0] POS = IDX_W'(LEAD_W + RESULT_W - 1 - i);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q[i] <= 1'b0;
         end else if (sample_i && (idx_i == POS)) begin
            data_q[i] <= miso_i;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pad_err_q <= 1'b0;
      end else if (clear_i) begin
         pad_err_q <= 1'b0;
      end else if (sample_i && (idx_i < LEAD_IDX) && miso_i) begin
         pad_err_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o <= '0;
         err_o    <= 1'b0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= end_i;
         if (end_i) begin
            result_o <= data_q;
            err_o    <= pad_err_q;
         end
      end
   end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
   parameter int DIV_W    = 12,
   parameter int GAP_W    = 8,
   parameter int LEAD_W   = 4,
   parameter int RESULT_W = 8,
   parameter int BYTE_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                minimal_i,
   input  logic                cpol_i,
   input  logic                sel_i,
   input  logic [DIV_W-1:0]    div_i,
   input  logic [GAP_W-1:0]    gap_i,
   input  logic                adc_miso_i,
   output logic                adc_cs_n_o,
   output logic                adc_sclk_o,
   output logic                adc_sel_o,
   output logic                busy_o,
   output logic                done_o,
   output logic [RESULT_W-1:0] result_o,
   output logic                err_o
);

   localparam int MIN_CLKS  = LEAD_W + RESULT_W;
   localparam int FULL_CLKS = 2 * BYTE_W;
   localparam int IDX_W     = $clog2(FULL_CLKS);

   if (LEAD_W < 1 || RESULT_W < 1) begin : g_bad_widths
      $error("adc_frame_reader: LEAD_W and RESULT_W must be at least 1");
   end
   if (FULL_CLKS < MIN_CLKS) begin : g_bad_frame
      $error("adc_frame_reader: byte frame shorter than padding plus result");
   end
   if (DIV_W < 1 || GAP_W < 1) begin : g_bad_timer
      $error("adc_frame_reader: timer widths must be at least 1");
   end

   logic             tick;
   logic             tick_clr;
   logic [DIV_W-1:0] div_lat;
   logic             frame_start;
   logic             sample;
   logic [IDX_W-1:0] sample_idx;
   logic             frame_end;

   adc_rd_tick #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (tick_clr),
      .div_i  (div_lat),
      .tick_o (tick)
   );

   adc_rd_seq #(
      .DIV_W     (DIV_W),
      .GAP_W     (GAP_W),
      .MIN_CLKS  (MIN_CLKS),
      .FULL_CLKS (FULL_CLKS),
      .IDX_W     (IDX_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .minimal_i     (minimal_i),
      .cpol_i        (cpol_i),
      .sel_i         (sel_i),
      .div_i         (div_i),
      .gap_i         (gap_i),
      .tick_i        (tick),
      .tick_clr_o    (tick_clr),
      .div_o         (div_lat),
      .cs_n_o        (adc_cs_n_o),
      .sclk_o        (adc_sclk_o),
      .sel_o         (adc_sel_o),
      .busy_o        (busy_o),
      .frame_start_o (frame_start),
      .sample_o      (sample),
      .sample_idx_o  (sample_idx),
      .frame_end_o   (frame_end)
   );

   adc_rd_capture #(
      .LEAD_W   (LEAD_W),
      .RESULT_W (RESULT_W),
      .IDX_W    (IDX_W)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (frame_start),
      .sample_i (sample),
      .idx_i    (sample_idx),
      .miso_i   (adc_miso_i),
      .end_i    (frame_end),
      .result_o (result_o),
      .err_o    (err_o),
      .valid_o  (done_o)
   );

endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
   parameter int RESULT_W  = 8,
   parameter int MIN_CLKS  = 12,
   parameter int FULL_CLKS = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic                minimal_i,
   input logic                adc_cs_n_o,
   input logic                adc_sclk_o,
   input logic                adc_sel_o,
   input logic                busy_o,
   input logic                done_o,
   input logic [RESULT_W-1:0] result_o,
   input logic                err_o
);

   logic       cs_d;
   logic       sclk_d;
   logic       mode_l;
   logic [5:0] rise_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_d     <= 1'b1;
         sclk_d   <= 1'b0;
         mode_l   <= 1'b0;
         rise_cnt <= '0;
      end else begin
         cs_d   <= adc_cs_n_o;
         sclk_d <= adc_sclk_o;
         if (start_i && !busy_o) mode_l <= minimal_i;
         if (cs_d && !adc_cs_n_o) begin
            rise_cnt <= '0;
         end else if (!adc_cs_n_o && adc_sclk_o && !sclk_d) begin
            rise_cnt <= rise_cnt + 1'b1;
         end
      end
   end

   // R2: no serial clock transition when chip-select changes
   p_quiet_clock_at_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_d != adc_cs_n_o) |-> (adc_sclk_o == sclk_d));

   // R3: rising edge count per frame length
   p_edge_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_d && adc_cs_n_o) |-> (rise_cnt == (mode_l ? 6'(MIN_CLKS) : 6'(FULL_CLKS))));

   // R5: select pin stable during the frame
   p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_cs_n_o |-> $stable(adc_sel_o));

   // R7: valid strobe is a single cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7: valid strobe coincides with chip-select release
   p_done_at_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (adc_cs_n_o && !cs_d));

   // R7: outputs change only with the strobe
   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(err_o)));

   // R9: no new request taken while busy
   p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(adc_sel_o));

   // R10: a frame lies inside the busy window
   p_cs_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_cs_n_o |-> busy_o);

endmodule

bind adc_frame_reader adc_frame_reader_chk #(
   .RESULT_W  (RESULT_W),
   .MIN_CLKS  (LEAD_W + RESULT_W),
   .FULL_CLKS (2 * BYTE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .minimal_i  (minimal_i),
   .adc_cs_n_o (adc_cs_n_o),
   .adc_sclk_o (adc_sclk_o),
   .adc_sel_o  (adc_sel_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .result_o   (result_o),
   .err_o      (err_o)
);

// File: tb/adc_frame_reader_tb_top.sv
`timescale 1ns/1ps
module adc_frame_reader_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        minimal = 1'b0;
   logic        cpol = 1'b0;
   logic        sel = 1'b0;
   logic [11:0] div = 12'd1;
   logic [7:0]  gap = 8'd0;
   logic        miso;
   logic        cs_n, sclk, sel_o, busy, done, err;
   logic [7:0]  result;

   always #2 clk = ~clk;

   adc_frame_reader dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .minimal_i(minimal),
      .cpol_i(cpol), .sel_i(sel), .div_i(div), .gap_i(gap),
      .adc_miso_i(miso), .adc_cs_n_o(cs_n), .adc_sclk_o(sclk),
      .adc_sel_o(sel_o), .busy_o(busy), .done_o(done),
      .result_o(result), .err_o(err)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // converter model: data moves on falling clock edges
   logic [15:0] fb = '0;
   int n_rise = 0;
   int drv = 0;
   logic m_sclk = 1'b0;
   always @(cs_n, sclk) begin
      if (cs_n) begin
         n_rise = 0;
         drv = 0;
      end else if (sclk !== m_sclk && sclk) begin
         n_rise++;
      end else if (sclk !== m_sclk && !sclk) begin
         drv = n_rise;
      end
      m_sclk = sclk;
   end
   assign miso = (!cs_n && drv < 16) ? fb[drv] : 1'b0;

   function automatic logic [7:0] exp_word(input logic [15:0] bits);
      logic [7:0] w;
      for (int j = 0; j < 8; j++) w[7-j] = bits[4+j];
      return w;
   endfunction

   function automatic logic exp_err(input logic [15:0] bits);
      return |bits[3:0];
   endfunction

   // timing monitor
   int   exp_div = 1, exp_edges = 16;
   logic exp_cpol = 1'b0, exp_sel = 1'b0;
   int   cyc = 0, t_ev = 0, rises = 0, frames_seen = 0;
   logic pcs = 1'b1, psclk = 1'b0, pbusy = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (busy && !pbusy) t_ev = cyc;
         if (!cs_n && pcs) begin
            chk(cyc - t_ev == exp_div, "R4", "busy-to-cs interval", cyc - t_ev, exp_div);
            chk(sclk == exp_cpol, "R2", "clock level at cs fall", sclk, exp_cpol);
            chk(sel_o == exp_sel, "R5", "select at cs fall", sel_o, exp_sel);
            t_ev = cyc;
            rises = 0;
            frames_seen++;
         end else if (!cs_n && sclk != psclk) begin
            chk(cyc - t_ev == exp_div, "R4", "clock half-period", cyc - t_ev, exp_div);
            t_ev = cyc;
            if (sclk) rises++;
         end else if (cs_n && !pcs) begin
            chk(cyc - t_ev == exp_div, "R4", "last edge to cs rise", cyc - t_ev, exp_div);
            chk(rises == exp_edges, "R3", "rising edges in frame", rises, exp_edges);
            chk(sclk == exp_cpol, "R2", "clock level at cs rise", sclk, exp_cpol);
            chk(sel_o == exp_sel, "R5", "select at cs rise", sel_o, exp_sel);
         end
      end
      pcs = cs_n;
      psclk = sclk;
      pbusy = busy;
   end

   task automatic run_frame(input logic m, input logic c, input logic s,
                            input int d, input int g, input logic [15:0] bits);
      logic [7:0] prev_res;
      logic       prev_err;
      int         n_busy;
      int         f0;
      @(negedge clk);
      minimal = m; cpol = c; sel = s; div = 12'(d); gap = 8'(g);
      fb = bits;
      exp_div = (d == 0) ? 1 : d;
      exp_edges = m ? 12 : 16;
      exp_cpol = c;
      exp_sel = s;
      @(negedge clk);
      @(negedge clk);
      chk(sclk == c, "R2", "idle clock level", sclk, c);
      prev_res = result;
      prev_err = err;
      f0 = frames_seen;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(sel_o == s, "R5", "select driven at accept", sel_o, s);
      while (cs_n) @(negedge clk);
      // R9: a request during the frame must be ignored
      sel = ~s; minimal = ~m; start = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0; sel = s; minimal = m;
      chk(sel_o == s, "R9", "select after ignored start", sel_o, s);
      chk(result == prev_res && err == prev_err, "R7", "result held mid-frame",
          result, prev_res);
      while (!done) @(negedge clk);
      chk(result == exp_word(bits), "R6", "result value", result, exp_word(bits));
      chk(err == exp_err(bits), "R8", "padding error flag", err, exp_err(bits));
      chk(cs_n == 1'b1, "R7", "cs high with done", cs_n, 1);
      n_busy = 0;
      while (busy && n_busy < 400) begin
         n_busy++;
         @(negedge clk);
      end
      chk(n_busy == ((g == 0) ? 1 : g), "R10", "busy cycles after done", n_busy,
          (g == 0) ? 1 : g);
      chk(frames_seen == f0 + 1, "R9", "frames started", frames_seen - f0, 1);
      chk(!done, "R7", "done single pulse", done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1, "R1", "reset cs", cs_n, 1);
      chk(sclk == 1'b0, "R1", "reset clock", sclk, 0);
      chk(!busy && !done, "R1", "reset busy/done", {busy, done}, 0);
      chk(result == 8'd0 && !err, "R1", "reset result", result, 0);
      rst_n = 1'b1;
      // directed corners
      run_frame(1'b0, 1'b0, 1'b1, 1, 0, 16'h0A50);
      run_frame(1'b1, 1'b1, 1'b0, 3, 1, 16'h0FF0);
      run_frame(1'b0, 1'b1, 1'b1, 0, 5, 16'hF3C0); // R6 trailing ones ignored
      run_frame(1'b1, 1'b0, 1'b0, 2, 2, 16'h0009); // R8 padding set
      run_frame(1'b0, 1'b0, 1'b0, 4, 3, 16'h0008);
      run_frame(1'b1, 1'b0, 1'b1, 1, 0, 16'h0FF1);
      // constrained random
      void'($urandom(32'h5EED_0001));
      for (int k = 0; k < 30; k++) begin
         logic [15:0] b;
         b = 16'($urandom);
         if (($urandom % 4) != 0) b[3:0] = 4'h0;
         run_frame(1'($urandom), 1'($urandom), 1'($urandom),
                   int'($urandom % 6), int'($urandom % 7), b);
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog: done seen 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule